// File: doc/BRIEF.md
# Decimal digit rotate through memory

This block carries out the two decimal-digit rotate operations of an 8-bit processor core. Each operation rotates three 4-bit digits, taken from the low nibble of the accumulator and from both nibbles of one memory byte, by one digit position. The accumulator's upper digit is not part of the rotation.

The core pulses `start_i` with the rotate direction, the accumulator, the incoming carry flag and the 16-bit pointer register value. The block reads the byte at that pointer and rotates the three digits. It writes the result byte back to the same address and then returns the new accumulator and flag byte on a one-cycle `done_o` pulse. The whole operation spans a fixed number of cycles, 18 by default, so the core's instruction timing stays unchanged. Memory reads are registered: read data is valid in the cycle after the read strobe.

Top module: `nib_rot_unit`

## Requirements
- R1: With `dir_left_i`=0 (rotate right), the written byte is {old accumulator bits 3:0, old memory bits 7:4}, and the new accumulator is {old accumulator bits 7:4, old memory bits 3:0}.
- R2: With `dir_left_i`=1 (rotate left), the written byte is {old memory bits 3:0, old accumulator bits 3:0}, and the new accumulator is {old accumulator bits 7:4, old memory bits 7:4}.
- R3: Bits 7:4 of the accumulator result always equal bits 7:4 of the accumulator given at start.
- R4: The following bits of the flag byte are taken from the new accumulator: bit 7 is its bit 7 (sign), bit 6 is 1 when it is zero, bit 5 is its bit 5, bit 3 is its bit 3, and bit 2 is 1 when it has an even number of one bits.
- R5: Flag bits 4 (half-carry) and 1 (subtract) are 0, and flag bit 0 equals `carry_i` as sampled at start.
- R6: Counting the cycle after the start edge as cycle 1, `mem_rd_o` is high in cycle 1, `mem_wr_o` is high in cycle CYCLES-1 and `done_o` is high in cycle CYCLES. `mem_addr_o` equals the `ptr_i` value sampled at start during both strobes.
- R7: While an operation is in progress, `start_i` is ignored. Changes on `acc_i`, `carry_i`, `dir_left_i` and `ptr_i` after the start edge do not affect that operation.
- R8: After reset, `mem_rd_o`, `mem_wr_o` and `done_o` are low, and `acc_o` and `flags_o` are zero.
- R9: Each operation issues exactly one read strobe and one write strobe, never in the same cycle. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| dir_left_i | input | 1 | 1 = rotate left, 0 = rotate right |
| acc_i | input | 8 | Accumulator value |
| carry_i | input | 1 | Incoming carry flag |
| ptr_i | input | 16 | Memory pointer for read and write |
| mem_addr_o | output | 16 | Memory address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_rd_o` |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| acc_o | output | 8 | New accumulator, held until the next completion |
| flags_o | output | 8 | New flag byte, held until the next completion |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit address and a span of 18 cycles. It checks every cycle of the span, so it confirms that the strobes sit in cycle 1 and cycle 17 and that the completion pulse falls in cycle 18. Random memory and accumulator bytes cover both directions and both carry values. Directed cases cover a zero result, odd and even parity results, and a restart attempt with changed inputs in the middle of an operation.

// File: rtl/nib_rot_pkg.sv
package nib_rot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CAP,
    ST_PAD,
    ST_WR,
    ST_FIN
  } rot_state_e;

  // Flag byte layout: 7 sign, 6 zero, 5 copy, 4 half, 3 copy, 2 parity, 1 sub, 0 carry
  localparam int unsigned FLAG_S = 7;
  localparam int unsigned FLAG_Z = 6;
  localparam int unsigned FLAG_Y = 5;
  localparam int unsigned FLAG_H = 4;
  localparam int unsigned FLAG_X = 3;
  localparam int unsigned FLAG_P = 2;
  localparam int unsigned FLAG_N = 1;
  localparam int unsigned FLAG_C = 0;

endpackage

// File: rtl/nib_rot_ctrl.sv
module nib_rot_ctrl
  import nib_rot_pkg::*;
#(
  parameter int unsigned CYCLES = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic take_o,
  output logic rd_o,
  output logic cap_o,
  output logic wr_o,
  output logic load_o,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(CYCLES - 2);

  rot_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  initial begin
    if (CYCLES < 5) $error("CYCLES must be at least 5");
  end

  assign take_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD;
      ST_RD:   state_d = ST_CAP;
      ST_CAP:  state_d = ST_PAD;
      ST_PAD:  if (cnt_q == PAD_LAST) state_d = ST_WR;
      ST_WR:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_o) cnt_q <= CNT_W'(1);
      else if (state_q != ST_IDLE) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign rd_o   = (state_q == ST_RD);
  assign cap_o  = (state_q == ST_CAP);
  assign wr_o   = (state_q == ST_WR);
  assign load_o = (state_q == ST_WR);
  assign done_o = (state_q == ST_FIN);

  // R9: strobes are single cycles and exclusive
  a_r9_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  a_r9_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: completion follows the write directly
  a_r6_wr_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> done_o);
  a_r6_start_then_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> rd_o);

endmodule

// File: rtl/nib_rot_flags.sv
module nib_rot_flags
  import nib_rot_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  output logic [7:0]        flags_o
);

  always_comb begin
    flags_o         = '0;
    flags_o[FLAG_S] = acc_i[DATA_W-1];
    flags_o[FLAG_Z] = (acc_i == '0);
    flags_o[FLAG_Y] = acc_i[5];
    flags_o[FLAG_X] = acc_i[3];
    flags_o[FLAG_P] = ~(^acc_i);
    flags_o[FLAG_C] = carry_i;
  end

endmodule

// File: rtl/nib_rot_dp.sv
module nib_rot_dp #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              cap_i,
  input  logic              load_i,
  input  logic              dir_left_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o
);

  localparam int unsigned NIB = DATA_W / 2;

  logic [DATA_W-1:0] acc_q, mem_q, acc_new, acc_r;
  logic [ADDR_W-1:0] ptr_q;
  logic              left_q, carry_q;
  logic [7:0]        flags_new, flags_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mem_q   <= '0;
      ptr_q   <= '0;
      left_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (take_i) begin
        acc_q   <= acc_i;
        ptr_q   <= ptr_i;
        left_q  <= dir_left_i;
        carry_q <= carry_i;
      end
      if (cap_i) mem_q <= mem_rdata_i;
    end
  end

  // Digit routing: each result bit picks its source by direction
  for (genvar b = 0; b < NIB; b++) begin : g_dig
    assign acc_new[b]       = left_q ? mem_q[NIB+b] : mem_q[b];
    assign acc_new[NIB+b]   = acc_q[NIB+b];
    assign wdata_o[b]       = left_q ? acc_q[b]     : mem_q[NIB+b];
    assign wdata_o[NIB+b]   = left_q ? mem_q[b]     : acc_q[b];
  end

  nib_rot_flags #(.DATA_W(DATA_W)) u_flags (
    .acc_i   (acc_new),
    .carry_i (carry_q),
    .flags_o (flags_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_r   <= '0;
      flags_r <= '0;
    end else if (load_i) begin
      acc_r   <= acc_new;
      flags_r <= flags_new;
    end
  end

  assign addr_o  = ptr_q;
  assign acc_o   = acc_r;
  assign flags_o = flags_r;

  // R7: operands held while the operation runs
  a_r7_ptr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i || load_i) |=> $stable(ptr_q));
  // R3: upper digit passes through on load
  a_r3_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_r[DATA_W-1:NIB] == acc_q[DATA_W-1:NIB]));
  // R5: half-carry and subtract cleared, carry kept
  a_r5_flag_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!flags_r[4] && !flags_r[1] && flags_r[0] == carry_q));

endmodule

// File: rtl/nib_rot_unit.sv
module nib_rot_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CYCLES = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_left_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o,
  output logic              done_o
);

  logic take, cap, load;

  nib_rot_ctrl #(.CYCLES(CYCLES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .take_o  (take),
    .rd_o    (mem_rd_o),
    .cap_o   (cap),
    .wr_o    (mem_wr_o),
    .load_o  (load),
    .done_o  (done_o)
  );

  nib_rot_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .cap_i       (cap),
    .load_i      (load),
    .dir_left_i  (dir_left_i),
    .acc_i       (acc_i),
    .carry_i     (carry_i),
    .ptr_i       (ptr_i),
    .mem_rdata_i (mem_rdata_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_wdata_o),
    .acc_o       (acc_o),
    .flags_o     (flags_o)
  );

  // R4: zero flag agrees with the result on completion
  a_r4_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[6] == (acc_o == '0)));
  // R4: parity flag reports even parity of the result
  a_r4_parity_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[2] == ~(^acc_o)));

endmodule

// File: tb/nib_rot_unit_tb.sv
module nib_rot_unit_tb;

  localparam int CYC = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir_left = 1'b0, carry = 1'b0;
  logic [7:0]  acc = '0, rdata = '0, mem_byte = '0;
  logic [15:0] ptr = '0;
  logic [15:0] addr;
  logic [7:0]  wdata, acc_o, flags_o;
  logic        rd, wr, done;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nib_rot_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_left_i(dir_left),
    .acc_i(acc), .carry_i(carry), .ptr_i(ptr), .mem_addr_o(addr),
    .mem_rdata_i(rdata), .mem_wdata_o(wdata), .mem_rd_o(rd), .mem_wr_o(wr),
    .acc_o(acc_o), .flags_o(flags_o), .done_o(done)
  );

  // registered memory read
  always @(posedge clk) if (rd) rdata <= mem_byte;

  function automatic logic [7:0] f_mem(input logic l, input logic [7:0] a, input logic [7:0] m);
    return l ? {m[3:0], a[3:0]} : {a[3:0], m[7:4]};
  endfunction
  function automatic logic [7:0] f_acc(input logic l, input logic [7:0] a, input logic [7:0] m);
    return l ? {a[7:4], m[7:4]} : {a[7:4], m[3:0]};
  endfunction
  function automatic logic [7:0] f_flags(input logic [7:0] r, input logic c);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    return {r[7], (r == 8'h00), r[5], 1'b0, r[3], (ones % 2 == 0), 1'b0, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic l, input logic [7:0] a, input logic c,
                        input logic [15:0] p, input logic [7:0] m, input bit perturb);
    logic [7:0] ea, em, ef;
    ea = f_acc(l, a, m); em = f_mem(l, a, m); ef = f_flags(ea, c);
    @(negedge clk);
    dir_left = l; acc = a; carry = c; ptr = p; mem_byte = m; start = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= CYC; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (perturb && k >= 2 && k <= 10) begin
        start = 1'b1; acc = ~a; carry = ~c; ptr = ~p; dir_left = ~l;
      end
      if (perturb && k == 11) start = 1'b0;
      if (k == 1 || k == CYC - 1 || k == CYC) begin
        chk("R6 rd", 32'(rd), 32'(k == 1));
        chk("R6 wr", 32'(wr), 32'(k == CYC - 1));
        chk("R6 done", 32'(done), 32'(k == CYC));
      end else if (rd || wr || done) begin
        chk("R9 stray strobe", {29'd0, rd, wr, done}, 32'd0);
      end
      if (k == 1) chk("R6 rd addr", 32'(addr), 32'(p));
      if (k == CYC - 1) begin
        chk("R6 wr addr", 32'(addr), 32'(p));
        chk(l ? "R2 wdata" : "R1 wdata", 32'(wdata), 32'(em));
      end
      if (k == CYC) begin
        chk(l ? "R2 acc" : "R1 acc", 32'(acc_o), 32'(ea));
        chk("R3 upper", 32'(acc_o[7:4]), 32'(a[7:4]));
        chk("R4 flags", 32'({flags_o[7:5], flags_o[3:2]}), 32'({ef[7:5], ef[3:2]}));
        chk("R5 flags", 32'({flags_o[4], flags_o[1:0]}), 32'({ef[4], ef[1:0]}));
        if (perturb) chk("R7 perturbed acc", 32'(acc_o), 32'(ea));
      end
    end
    @(negedge clk);
    chk("R9 done single", 32'(done), 32'd0);
  endtask

  initial begin
    int seed = 32'h1d5;
    void'($urandom(seed));
    #1;
    chk("R8 rd", 32'(rd), 32'd0);
    chk("R8 wr", 32'(wr), 32'd0);
    chk("R8 done", 32'(done), 32'd0);
    chk("R8 acc", 32'(acc_o), 32'd0);
    chk("R8 flags", 32'(flags_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed: right, zero result, carry kept
    run_op(1'b0, 8'h05, 1'b1, 16'h1234, 8'hA0, 1'b0);
    // directed: left, zero result
    run_op(1'b1, 8'h03, 1'b0, 16'hFFFF, 8'h09, 1'b0);
    // directed: sign + odd parity
    run_op(1'b0, 8'h80, 1'b0, 16'h0000, 8'h00, 1'b0);
    // directed: all ones
    run_op(1'b1, 8'hFF, 1'b1, 16'h8001, 8'hFF, 1'b0);
    // directed: R7 restart attempt mid-operation
    run_op(1'b0, 8'h5A, 1'b0, 16'h4321, 8'h3C, 1'b1);
    run_op(1'b1, 8'hC3, 1'b1, 16'h0F0F, 8'h96, 1'b1);
    for (int n = 0; n < 150; n++)
      run_op(1'($urandom), 8'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), (n % 7) == 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule